// File: doc/BRIEF.md
# PCI Type-0 Configuration Header

This block holds the 64-byte type-0 configuration header of one PCI function. A configuration master reaches it through a plain strobe bus: an 8-bit byte offset, read and write strobes, a 2-bit width code and 32-bit data. An access is taken in any cycle where the block is idle. Writes take effect at the accepting clock edge. The block then answers with a one-cycle `cfg_ready` pulse that carries the read data and an error flag.

Identity fields, header type, interrupt pin and the grant/latency limits are parameters and cannot be written. Command, status, cache line size, latency timer, interrupt line and the expansion ROM register can be written, each only at the access widths the rules below allow. There are six base-address slots. Each one answers a size probe, keeps its type bits, and drives a decoded base address and an enable to address-match logic downstream. Any slot can instead be set up as a fixed legacy I/O window.

Top module: `pci_cfg_hdr`

## Requirements
- R1: After reset, every read-only field reads its parameter value. Command, cache line size and latency timer read 0. Status, interrupt line and the ROM register read their reset parameters. Each BAR reads its reset value, or 0 if it is legacy. Every non-legacy BAR has `bar_en` low and a decoded base of 0.
- R2: An accepted access produces `cfg_ready` high for exactly one cycle, WAIT_CYCLES+1 rising edges after the accepting edge. Strobes that arrive while an access is pending are not taken.
- R3: Width code 3 raises `cfg_err`, as does any offset of 0x40 or above. Such an access changes no register and returns data 0.
- R4: Width codes 0, 1 and 2 select 1, 2 and 4 bytes. Read data is little-endian and begins at the addressed byte: byte offset+k goes to data bits [8k+7:8k]. Unused upper bytes are 0, and so are bytes past offset 0x3F.
- R5: A byte write to 0x3C (interrupt line), 0x0C (cache line) or 0x0D (latency) stores the byte. A byte write to 0x08–0x0B or 0x3D–0x3F is ignored with no error. A byte write to any other offset raises `cfg_err` and changes nothing.
- R6: A halfword write to 0x04 stores the command register and one to 0x06 stores status. A halfword write to 0x0C stores its low byte into cache line size. Any other halfword offset raises `cfg_err`.
- R7: A dword write of 0xFFFFFFFF to BAR n (offset 0x10+4n) loads ~(SIZE−1) into its address bits. A following read returns that size mask with the type bits kept, so a size of 0 reads as all address bits zero. A size that is neither 0 nor a power of two stops elaboration.
- R8: A BAR write never changes its type bits. If bit 0 of the BAR is 1 (I/O), bits [1:0] are kept; if bit 0 is 0 (memory), bits [3:0] are kept.
- R9: A non-probe BAR write with a nonzero masked address sets `bar_base[n]` to that address and raises `bar_en[n]`. A masked address of zero, or a probe, leaves the decoded base and enable unchanged.
- R10: A legacy BAR always reads 0 and ignores writes. Its decoded base is fixed at its parameter address, with `bar_en` high.
- R11: A dword write of 0xFFFFFFFE to 0x30 makes the ROM register read 0xFFFFFFFF. Any other dword value written there is stored as written.
- R12: A dword write to 0x04 stores its low 16 bits into the command register. A dword write to any other offset below 0x40 that is not a BAR or the ROM register is ignored with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | ADDR_W | Byte offset of the access |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe (wins over read) |
| cfg_size | input | 2 | Width code: 0 byte, 1 halfword, 2 dword, 3 invalid |
| cfg_wdata | input | 32 | Write data, little-endian |
| cfg_rdata | output | 32 | Read data, valid with cfg_ready |
| cfg_ready | output | 1 | One-cycle response pulse |
| cfg_err | output | 1 | Access error, valid with cfg_ready |
| bar_base | output | 6*32 | Decoded base address per BAR, BAR n at [32n+31:32n] |
| bar_en | output | 6 | Decode enable per BAR |

## Verification
Some properties are checked on every cycle. A response pulse is never longer than one cycle. An erroring access leaves the writable registers untouched. Halfword command writes and the ROM probe land exactly. Inside each BAR slot, the type bits survive every write, a probe loads the size mask, and a probe leaves the decoded base alone. The bench scenarios are what show the rest: the exact response latency, little-endian byte placement for each width, the per-width sets of writable, ignored and erroring offsets, zero-masked BAR writes, and fixed legacy windows.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int NUM_BARS  = 6;
  localparam int HDR_BYTES = 64;
  localparam int BAR_W     = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } cfg_size_e;
endpackage

// File: rtl/cfg_resp_timer.sv
module cfg_resp_timer #(
  parameter int WAIT_CYCLES = 2,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              err_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              busy,
  output logic              ready,
  output logic              err_out,
  output logic [DATA_W-1:0] data_out
);
  localparam int CW = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);

  logic              busy_q, busy_d, ready_q, ready_d, err_q, err_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    data_d  = data_q;
    err_d   = err_q;
    ready_d = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CW'(WAIT_CYCLES);
      data_d = data_in;
      err_d  = err_in;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d  = 1'b0;
        ready_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      data_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      ready_q <= ready_d;
      err_q   <= err_d;
      cnt_q   <= cnt_d;
      data_q  <= data_d;
    end
  end

  assign busy     = busy_q;
  assign ready    = ready_q;
  assign err_out  = ready_q & err_q;
  assign data_out = ready_q ? data_q : '0;

  assert_ready_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q);
  assert_accept_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && !ready_q));
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
  parameter logic [31:0] SIZE        = 32'h0,
  parameter logic [31:0] INIT        = 32'h0,
  parameter bit          LEGACY      = 1'b0,
  parameter logic [31:0] LEGACY_ADDR = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rd_val,
  output logic [31:0] base,
  output logic        en
);
  localparam logic [31:0] SIZE_MASK = ~(SIZE - 32'd1);

  if (!LEGACY && SIZE != 32'd0 && (SIZE & (SIZE - 32'd1)) != 32'd0) begin : g_bad_size
    $error("cfg_bar_slot: SIZE must be zero or a power of two");
  end

  logic [31:0] bar_q, bar_d, base_q, base_d, type_mask, new_addr;
  logic        en_q, en_d, wr_ok, probe;

  assign wr_ok     = we && !LEGACY;
  assign probe     = (wdata == 32'hFFFF_FFFF);
  assign type_mask = bar_q[0] ? 32'h0000_0003 : 32'h0000_000F;
  assign new_addr  = probe ? SIZE_MASK : (wdata & ~type_mask);

  always_comb begin
    bar_d  = bar_q;
    base_d = base_q;
    en_d   = en_q;
    if (wr_ok) begin
      bar_d = (new_addr & ~type_mask) | (bar_q & type_mask);
      if (!probe && new_addr != 32'd0) begin
        base_d = new_addr;
        en_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar_q  <= INIT;
      base_q <= '0;
      en_q   <= 1'b0;
    end else begin
      bar_q  <= bar_d;
      base_q <= base_d;
      en_q   <= en_d;
    end
  end

  assign rd_val = LEGACY ? 32'd0 : bar_q;
  assign base   = LEGACY ? LEGACY_ADDR : base_q;
  assign en     = LEGACY ? 1'b1 : en_q;

  assert_type_bits_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> ((bar_q & $past(type_mask)) == $past(bar_q & type_mask)));
  assert_probe_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && probe) |=> ((bar_q & ~$past(type_mask)) == (SIZE_MASK & ~$past(type_mask))));
  assert_probe_keeps_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && probe) |=> ($stable(base_q) && $stable(en_q)));
endmodule

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr
  import pci_cfg_pkg::*;
#(
  parameter int                       ADDR_W        = 8,
  parameter int                       WAIT_CYCLES   = 2,
  parameter logic [15:0]              VENDOR_ID     = 16'hABCD,
  parameter logic [15:0]              DEVICE_ID     = 16'h0001,
  parameter logic [7:0]               REV_ID        = 8'h01,
  parameter logic [23:0]              CLASS_CODE    = 24'h020000,
  parameter logic [7:0]               HDR_TYPE      = 8'h00,
  parameter logic [15:0]              SUB_VID       = 16'h0000,
  parameter logic [15:0]              SUB_ID        = 16'h0000,
  parameter logic [7:0]               INT_PIN       = 8'h01,
  parameter logic [7:0]               MIN_GNT       = 8'h00,
  parameter logic [7:0]               MAX_LAT       = 8'h00,
  parameter logic [15:0]              STATUS_INIT   = 16'h0000,
  parameter logic [7:0]               INT_LINE_INIT = 8'h00,
  parameter logic [31:0]              ROM_INIT      = 32'h0,
  parameter logic [NUM_BARS*32-1:0]   BAR_SIZE      = {32'h0, 32'h0, 32'h0, 32'h0, 32'h100, 32'h1000},
  parameter logic [NUM_BARS*32-1:0]   BAR_INIT      = {32'h0, 32'h0, 32'h0, 32'h0, 32'h1, 32'h0},
  parameter logic [NUM_BARS-1:0]      BAR_LEGACY    = '0,
  parameter logic [NUM_BARS*32-1:0]   BAR_LEG_ADDR  = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic                   cfg_rd,
  input  logic                   cfg_wr,
  input  logic [1:0]             cfg_size,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  output logic                   cfg_ready,
  output logic                   cfg_err,
  output logic [NUM_BARS*32-1:0] bar_base,
  output logic [NUM_BARS-1:0]    bar_en
);
  localparam int OFF_W = $clog2(HDR_BYTES);

  cfg_size_e          size_e;
  logic [OFF_W-1:0]   off;
  logic               busy, acc, bad_size, bad_off, wr_go, wr_err, req_err;
  logic [15:0]        cmd_q, cmd_d, sts_q, sts_d;
  logic [7:0]         cls_q, cls_d, lat_q, lat_d, intl_q, intl_d;
  logic [31:0]        rom_q, rom_d, rd_word, resp_data;
  logic [NUM_BARS-1:0] bar_we;
  logic [31:0]        bar_rd [NUM_BARS];
  logic [8*HDR_BYTES-1:0] hdr;

  assign size_e   = cfg_size_e'(cfg_size);
  assign off      = cfg_addr[OFF_W-1:0];
  assign acc      = (cfg_rd || cfg_wr) && !busy;
  assign bad_size = (size_e == SZ_BAD);
  assign bad_off  = (cfg_addr[ADDR_W-1:OFF_W] != '0);
  assign wr_go    = acc && cfg_wr && !bad_size && !bad_off;

  // Write decode by access width
  always_comb begin
    cmd_d  = cmd_q;
    sts_d  = sts_q;
    cls_d  = cls_q;
    lat_d  = lat_q;
    intl_d = intl_q;
    rom_d  = rom_q;
    bar_we = '0;
    wr_err = 1'b0;
    if (wr_go) begin
      case (size_e)
        SZ_BYTE: begin
          case (off)
            6'h3C: intl_d = cfg_wdata[7:0];
            6'h0C: cls_d  = cfg_wdata[7:0];
            6'h0D: lat_d  = cfg_wdata[7:0];
            6'h08, 6'h09, 6'h0A, 6'h0B, 6'h3D, 6'h3E, 6'h3F: begin end
            default: wr_err = 1'b1;
          endcase
        end
        SZ_HALF: begin
          case (off)
            6'h04: cmd_d = cfg_wdata[15:0];
            6'h06: sts_d = cfg_wdata[15:0];
            6'h0C: cls_d = cfg_wdata[7:0];
            default: wr_err = 1'b1;
          endcase
        end
        default: begin
          if (off == 6'h04) cmd_d = cfg_wdata[15:0];
          if (off == 6'h30) rom_d = (cfg_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : cfg_wdata;
          for (int i = 0; i < NUM_BARS; i++) begin
            if (off == OFF_W'(16 + 4 * i)) bar_we[i] = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      sts_q  <= STATUS_INIT;
      cls_q  <= '0;
      lat_q  <= '0;
      intl_q <= INT_LINE_INIT;
      rom_q  <= ROM_INIT;
    end else begin
      cmd_q  <= cmd_d;
      sts_q  <= sts_d;
      cls_q  <= cls_d;
      lat_q  <= lat_d;
      intl_q <= intl_d;
      rom_q  <= rom_d;
    end
  end

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    cfg_bar_slot #(
      .SIZE        (BAR_SIZE[g*32 +: 32]),
      .INIT        (BAR_INIT[g*32 +: 32]),
      .LEGACY      (BAR_LEGACY[g]),
      .LEGACY_ADDR (BAR_LEG_ADDR[g*32 +: 32])
    ) u_bar (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bar_we[g]),
      .wdata  (cfg_wdata),
      .rd_val (bar_rd[g]),
      .base   (bar_base[g*32 +: 32]),
      .en     (bar_en[g])
    );
  end

  // Flat little-endian view of the header
  always_comb begin
    hdr = '0;
    hdr[0   +: 16] = VENDOR_ID;
    hdr[16  +: 16] = DEVICE_ID;
    hdr[32  +: 16] = cmd_q;
    hdr[48  +: 16] = sts_q;
    hdr[64  +: 8]  = REV_ID;
    hdr[72  +: 24] = CLASS_CODE;
    hdr[96  +: 8]  = cls_q;
    hdr[104 +: 8]  = lat_q;
    hdr[112 +: 8]  = HDR_TYPE;
    for (int i = 0; i < NUM_BARS; i++) hdr[(16 + 4 * i) * 8 +: 32] = bar_rd[i];
    hdr[352 +: 16] = SUB_VID;
    hdr[368 +: 16] = SUB_ID;
    hdr[384 +: 32] = rom_q;
    hdr[480 +: 8]  = intl_q;
    hdr[488 +: 8]  = INT_PIN;
    hdr[496 +: 8]  = MIN_GNT;
    hdr[504 +: 8]  = MAX_LAT;
  end

  always_comb begin
    logic [OFF_W:0] idx;
    rd_word = '0;
    for (int k = 0; k < 4; k++) begin
      idx = {1'b0, off} + (OFF_W + 1)'(k);
      if (!idx[OFF_W] && (k == 0 || (k == 1 && size_e != SZ_BYTE) || size_e == SZ_WORD))
        rd_word[8*k +: 8] = hdr[idx[OFF_W-1:0] * 8 +: 8];
    end
  end

  assign req_err   = bad_size || bad_off || wr_err;
  assign resp_data = (cfg_wr || req_err) ? 32'd0 : rd_word;

  cfg_resp_timer #(.WAIT_CYCLES(WAIT_CYCLES), .DATA_W(32)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (acc),
    .err_in   (req_err),
    .data_in  (resp_data),
    .busy     (busy),
    .ready    (cfg_ready),
    .err_out  (cfg_err),
    .data_out (cfg_rdata)
  );

  assert_err_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (bad_size || bad_off)) |=> ($stable(cmd_q) && $stable(rom_q) && $stable(intl_q) && $stable(sts_q)));
  assert_half_cmd_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && size_e == SZ_HALF && off == 6'h04) |=> (cmd_q == $past(cfg_wdata[15:0])));
  assert_rom_probe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && size_e == SZ_WORD && off == 6'h30 && cfg_wdata == 32'hFFFF_FFFE) |=> (rom_q == 32'hFFFF_FFFF));
  assert_single_bar_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bar_we));
endmodule

// File: tb/pci_cfg_hdr_test.sv
module pci_cfg_hdr_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYC   = 3;

  logic        clk, rst_n, cfg_rd, cfg_wr, cfg_ready, cfg_err;
  logic [7:0]  cfg_addr;
  logic [1:0]  cfg_size;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [191:0] bar_base;
  logic [5:0]  bar_en;

  int total = 0;
  int fails = 0;
  int last_lat;

  pci_cfg_hdr #(
    .WAIT_CYCLES   (WAIT_CYC),
    .VENDOR_ID     (16'h1AB2),
    .DEVICE_ID     (16'h3C4D),
    .REV_ID        (8'h05),
    .CLASS_CODE    (24'h020000),
    .SUB_VID       (16'h5566),
    .SUB_ID        (16'h7788),
    .INT_PIN       (8'h01),
    .MIN_GNT       (8'h10),
    .MAX_LAT       (8'h20),
    .STATUS_INIT   (16'h0010),
    .INT_LINE_INIT (8'h0B),
    .ROM_INIT      (32'h0),
    .BAR_SIZE      ({32'h0, 32'h0010_0000, 32'h0, 32'h0, 32'h100, 32'h1000}),
    .BAR_INIT      ({32'h0, 32'h8, 32'h0, 32'h0, 32'h1, 32'h0}),
    .BAR_LEGACY    (6'b000100),
    .BAR_LEG_ADDR  ({32'h0, 32'h0, 32'h0, 32'h3F8, 32'h0, 32'h0})
  ) uut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_ready(cfg_ready), .cfg_err(cfg_err), .bar_base(bar_base), .bar_en(bar_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    fails++;
    $display("FAIL watchdog: act=hung exp=finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output logic er);
    int n;
    @(negedge clk);
    cfg_addr = addr; cfg_size = sz; cfg_wdata = wd; cfg_wr = wr; cfg_rd = !wr;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0;
    n = 0;
    while (!cfg_ready && n < 50) begin
      @(posedge clk); n++; @(negedge clk);
    end
    last_lat = n;
    rd = cfg_rdata;
    er = cfg_err;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] exp);
    logic [31:0] d; logic e;
    access(1'b0, a, sz, 32'h0, d, e);
    chk(req, d, exp);
  endtask

  task automatic wr_chk(input string req, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic exp_err);
    logic [31:0] d; logic e;
    access(1'b1, a, sz, wd, d, e);
    chk(req, {31'b0, e}, {31'b0, exp_err});
  endtask

  task automatic t_reset();
    rd_chk("R1 id dword", 8'h00, 2'd2, 32'h3C4D_1AB2);
    rd_chk("R1 cmd/status", 8'h04, 2'd2, 32'h0010_0000);
    rd_chk("R1 int dword", 8'h3C, 2'd2, 32'h2010_010B);
    rd_chk("R1 bar1 init", 8'h14, 2'd2, 32'h1);
    rd_chk("R1 bar4 init", 8'h20, 2'd2, 32'h8);
    rd_chk("R1 legacy bar2 reads 0", 8'h18, 2'd2, 32'h0);
    chk("R1 bar_en", {26'b0, bar_en}, 32'h4);
    chk("R1 bar0 base", bar_base[31:0], 32'h0);
    chk("R1 bar4 base", bar_base[159:128], 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] d; logic e;
    access(1'b0, 8'h00, 2'd0, 32'h0, d, e);
    chk("R2 read latency", last_lat, WAIT_CYC + 1);
    access(1'b1, 8'h3C, 2'd0, 32'h0B, d, e);
    chk("R2 write latency", last_lat, WAIT_CYC + 1);
    @(negedge clk);
    chk("R2 ready one cycle", {31'b0, cfg_ready}, 32'h0);
  endtask

  task automatic t_errors();
    logic [31:0] d; logic e;
    access(1'b0, 8'h00, 2'd3, 32'h0, d, e);
    chk("R3 bad size err", {31'b0, e}, 32'h1);
    chk("R3 bad size data", d, 32'h0);
    access(1'b0, 8'h40, 2'd2, 32'h0, d, e);
    chk("R3 region err", {31'b0, e}, 32'h1);
    wr_chk("R3 region write err", 8'h44, 2'd2, 32'h0000_0007, 1'b1);
    wr_chk("R3 bad size write err", 8'h04, 2'd3, 32'h0000_0007, 1'b1);
    rd_chk("R3 cmd untouched", 8'h04, 2'd1, 32'h0);
  endtask

  task automatic t_endian();
    rd_chk("R4 byte 1", 8'h01, 2'd0, 32'h1A);
    rd_chk("R4 half 2", 8'h02, 2'd1, 32'h3C4D);
    rd_chk("R4 class dword", 8'h08, 2'd2, 32'h0200_0005);
    rd_chk("R4 int pin byte", 8'h3D, 2'd0, 32'h01);
    rd_chk("R4 dword past end", 8'h3E, 2'd2, 32'h0000_2010);
  endtask

  task automatic t_byte_wr();
    wr_chk("R5 int line write", 8'h3C, 2'd0, 32'h5A, 1'b0);
    rd_chk("R5 int line value", 8'h3C, 2'd0, 32'h5A);
    wr_chk("R5 latency write", 8'h0D, 2'd0, 32'h40, 1'b0);
    wr_chk("R5 cache write", 8'h0C, 2'd0, 32'h08, 1'b0);
    rd_chk("R5 cache/latency", 8'h0C, 2'd1, 32'h4008);
    wr_chk("R5 int pin ignored", 8'h3D, 2'd0, 32'h77, 1'b0);
    wr_chk("R5 revision ignored", 8'h08, 2'd0, 32'h77, 1'b0);
    rd_chk("R5 pin/rev unchanged", 8'h3D, 2'd0, 32'h01);
    rd_chk("R5 rev unchanged", 8'h08, 2'd0, 32'h05);
    wr_chk("R5 vendor byte err", 8'h00, 2'd0, 32'hFF, 1'b1);
    rd_chk("R5 vendor unchanged", 8'h00, 2'd1, 32'h1AB2);
  endtask

  task automatic t_half_wr();
    wr_chk("R6 cmd half", 8'h04, 2'd1, 32'h0146, 1'b0);
    wr_chk("R6 status half", 8'h06, 2'd1, 32'h0230, 1'b0);
    rd_chk("R6 cmd/status", 8'h04, 2'd2, 32'h0230_0146);
    wr_chk("R6 cache half", 8'h0C, 2'd1, 32'hEE10, 1'b0);
    rd_chk("R6 cache low only", 8'h0C, 2'd1, 32'h4010);
    wr_chk("R6 bad half err", 8'h00, 2'd1, 32'h1234, 1'b1);
  endtask

  task automatic t_probe();
    wr_chk("R7 probe bar0", 8'h10, 2'd2, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R7 bar0 mask", 8'h10, 2'd2, 32'hFFFF_F000);
    wr_chk("R7 probe bar1", 8'h14, 2'd2, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R7 bar1 io mask", 8'h14, 2'd2, 32'hFFFF_FF01);
    wr_chk("R7 probe bar3", 8'h1C, 2'd2, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R7 bar3 size0", 8'h1C, 2'd2, 32'h0);
    chk("R7 probe no enable", {26'b0, bar_en}, 32'h4);
  endtask

  task automatic t_type();
    wr_chk("R8 bar4 write", 8'h20, 2'd2, 32'h1234_5677, 1'b0);
    rd_chk("R8 bar4 type kept", 8'h20, 2'd2, 32'h1234_5678);
    wr_chk("R8 bar1 write", 8'h14, 2'd2, 32'h0000_C002, 1'b0);
    rd_chk("R8 bar1 type kept", 8'h14, 2'd2, 32'h0000_C001);
  endtask

  task automatic t_decode();
    chk("R9 bar4 base", bar_base[159:128], 32'h1234_5670);
    chk("R9 bar1 base", bar_base[63:32], 32'h0000_C000);
    wr_chk("R9 bar0 write", 8'h10, 2'd2, 32'hA000_0000, 1'b0);
    chk("R9 bar0 base", bar_base[31:0], 32'hA000_0000);
    chk("R9 bar0 en", {31'b0, bar_en[0]}, 32'h1);
    wr_chk("R9 bar0 probe", 8'h10, 2'd2, 32'hFFFF_FFFF, 1'b0);
    chk("R9 probe keeps base", bar_base[31:0], 32'hA000_0000);
    wr_chk("R9 bar0 zero write", 8'h10, 2'd2, 32'h0000_0005, 1'b0);
    rd_chk("R9 bar0 reads 0", 8'h10, 2'd2, 32'h0);
    chk("R9 zero keeps base", bar_base[31:0], 32'hA000_0000);
  endtask

  task automatic t_legacy();
    wr_chk("R10 legacy write", 8'h18, 2'd2, 32'h1234_5678, 1'b0);
    rd_chk("R10 legacy reads 0", 8'h18, 2'd2, 32'h0);
    chk("R10 legacy base", bar_base[95:64], 32'h3F8);
    chk("R10 legacy en", {31'b0, bar_en[2]}, 32'h1);
  endtask

  task automatic t_rom();
    wr_chk("R11 rom probe", 8'h30, 2'd2, 32'hFFFF_FFFE, 1'b0);
    rd_chk("R11 rom all ones", 8'h30, 2'd2, 32'hFFFF_FFFF);
    wr_chk("R11 rom value", 8'h30, 2'd2, 32'h000C_0001, 1'b0);
    rd_chk("R11 rom stored", 8'h30, 2'd2, 32'h000C_0001);
  endtask

  task automatic t_dword_misc();
    wr_chk("R12 cmd dword", 8'h04, 2'd2, 32'hFFFF_0007, 1'b0);
    rd_chk("R12 cmd value", 8'h04, 2'd2, 32'h0230_0007);
    wr_chk("R12 id dword ignored", 8'h00, 2'd2, 32'h0, 1'b0);
    rd_chk("R12 id unchanged", 8'h00, 2'd2, 32'h3C4D_1AB2);
    wr_chk("R12 subsys ignored", 8'h2C, 2'd2, 32'h0, 1'b0);
    rd_chk("R12 subsys unchanged", 8'h2C, 2'd2, 32'h7788_5566);
  endtask

  initial begin
    rst_n = 1'b0; cfg_rd = 1'b0; cfg_wr = 1'b0;
    cfg_addr = '0; cfg_size = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_errors();
    t_endian();
    t_byte_wr();
    t_half_wr();
    t_probe();
    t_type();
    t_decode();
    t_legacy();
    t_rom();
    t_dword_misc();
    summary();
    $finish;
  end
endmodule